// File: doc/BRIEF.md
# Banked Register File Port Arbiter

This block is the arbitration stage between instruction select and register read in a wide-issue multithreaded core. The core's physical register file is split into banks, and each bank has only a few read and write ports. Instructions are issued without first checking whether their banks have free ports. Each cycle this stage receives the issue group: per slot, a valid bit, two source tags with use and bypass flags, and one destination tag with its result data. It counts, per bank, the distinct registers that must be read and the destinations that must be written. It grants instructions in slot order while they fit. At the first instruction that does not fit, it kills that instruction and every younger one in the group so that they can be reissued.

Each granted read is steered onto a numbered read port of its bank. The port number and the bank number go back to the read stage, along with the data read through that port. The bank storage is part of the block. A granted destination is written through a numbered write port of its bank, so reads and writes can both be observed at the ports.

Top module: `rf_bank_arb`

## Requirements
- R1: After a synchronous active-low reset, `grant_vld`, `kill_mask`, `opnd_rd`, `opnd_port` and `dst_port` are zero, and every register in the file holds zero.
- R2: A 9-bit tag selects bank `tag[3:0]` and entry `tag[8:4]`. `opnd_bank` reports `tag[3:0]` of each source.
- R3: A group presented before a rising edge is reported on the outputs after that edge and is held for exactly one cycle. No slot is ever both granted and killed.
- R4: If, counted over all valid slots, no bank needs more than 4 distinct read registers or more than 2 destinations, every valid slot is granted and none is killed.
- R5: A source with its bypass flag set takes no read port and reports `opnd_rd` = 0. A group that fits only because of that bypass is fully granted.
- R6: Reads of the same register in the same cycle share one read port and report the same `opnd_port`, whether they come from the same slot or from different slots. Only distinct registers count toward a bank's 4 read ports.
- R7: Read ports of a bank are handed out from 0 upward, in the order of first request: by slot, then source 0 before source 1. For each read, `opnd_data` returns the register's contents through that port. `opnd_data` is zero for an operand that is not read.
- R8: If a slot needs a fifth distinct read register in any bank, that slot and every younger valid slot are killed. Older slots are still granted.
- R9: Write ports of a bank are handed out from 0 upward in slot order and reported in `dst_port`. A slot that would need a third write port in a bank is killed, together with every younger valid slot.
- R10: An invalid slot is neither granted nor killed, and its operands take no ports.
- R11: A granted destination writes its data into its register. A read in the group presented in the next cycle returns the new value. A killed slot writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_vld | input | 8 | Valid bit per issue slot, slot 0 oldest |
| src_use | input | 8x2 | Source operand present |
| src_byp | input | 8x2 | Source operand is supplied by the bypass network |
| src_tag | input | 8x2x9 | Source physical register tag |
| dst_use | input | 8 | Slot writes a destination |
| dst_tag | input | 8x9 | Destination physical register tag |
| dst_data | input | 8x64 | Result data to be written for the destination |
| grant_vld | output | 8 | Slot granted |
| kill_mask | output | 8 | Slot killed, to be reissued |
| opnd_rd | output | 8x2 | Operand is read from the file |
| opnd_bank | output | 8x2x4 | Bank of the source operand |
| opnd_port | output | 8x2x2 | Read port assigned within the bank |
| opnd_data | output | 8x2x64 | Data read through the assigned port |
| dst_port | output | 8x1 | Write port assigned within the bank |

## Verification
The hardest case to reach is an instruction that partly fits: one source finds a port and the other does not. Its tentative port must not stay allocated, and the port numbers handed to older slots must stay correct while sharing and bypass change the distinct-register counts. Directed groups set up this edge exactly. Some fill a bank to four distinct registers with shared and bypassed reads. Others place a single slot's second source as the fifth register. Others make a third destination in a bank fail, after which a read in the next cycle shows the killed write missing. A run of random groups then draws tags from three banks and three entries, so that conflicts, sharing, bypass and invalid slots mix in every cycle. The grant and kill masks are compared against a model that recounts distinct registers per bank for each candidate slot.

// File: rtl/rfba_pkg.sv
// Package rfba_pkg
// Default sizes of the banked register file arbiter and a small width helper.
// Assumes nothing beyond elaboration-time constants.
package rfba_pkg;

    localparam int unsigned RFBA_NREG  = 512;
    localparam int unsigned RFBA_DW    = 64;
    localparam int unsigned RFBA_NBANK = 16;
    localparam int unsigned RFBA_RP    = 4;
    localparam int unsigned RFBA_WP    = 2;
    localparam int unsigned RFBA_ISSUE = 8;
    localparam int unsigned RFBA_NSRC  = 2;

    // Width of an index into n things, at least one bit.
    function automatic int unsigned idx_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/rfba_bank.sv
// Module rfba_bank
// One bank of the register file. Each read port returns its entry combinationally
// when enabled and zero otherwise. Writes take effect on the clock edge; if two
// write ports hit one entry, the higher port wins.
// Assumes the arbiter never assigns one entry to two write ports with
// different data in one cycle.
module rfba_bank #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned DW    = 64,
    parameter int unsigned RP    = 4,
    parameter int unsigned WP    = 2,
    localparam int unsigned EW   = (DEPTH < 2) ? 1 : $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [RP-1:0]               rd_en,
    input  logic [RP-1:0][EW-1:0]       rd_ent,
    output logic [RP-1:0][DW-1:0]       rd_data,
    input  logic [WP-1:0]               wr_en,
    input  logic [WP-1:0][EW-1:0]       wr_ent,
    input  logic [WP-1:0][DW-1:0]       wr_data
);

    logic [DW-1:0] mem [DEPTH];

    // Storage update: clear on reset, otherwise apply enabled write ports in order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) mem[e] <= '0;
        end else begin
            for (int w = 0; w < WP; w++)
                if (wr_en[w]) mem[wr_ent[w]] <= wr_data[w];
        end
    end

    // Read ports: drive the addressed entry or zero when the port is idle.
    always_comb begin
        for (int p = 0; p < RP; p++)
            rd_data[p] = rd_en[p] ? mem[rd_ent[p]] : '0;
    end

endmodule

// File: rtl/rfba_alloc.sv
// Module rfba_alloc
// Combinational port allocator. Walks the issue slots oldest first. For each
// slot it tentatively places the reads (sharing a port already open on the same
// register) and the destination. The slot commits only if all of them fit and
// no older slot failed; otherwise the slot is killed, its tentative ports are
// dropped, and every younger valid slot is killed too.
// Assumes tags are bank in the low bits, entry in the high bits.
module rfba_alloc #(
    parameter int unsigned NBANK = 16,
    parameter int unsigned RP    = 4,
    parameter int unsigned WP    = 2,
    parameter int unsigned ISSUE = 8,
    parameter int unsigned NSRC  = 2,
    parameter int unsigned TW    = 9,
    localparam int unsigned BW   = (NBANK < 2) ? 1 : $clog2(NBANK),
    localparam int unsigned EW   = TW - BW,
    localparam int unsigned PW   = (RP < 2) ? 1 : $clog2(RP),
    localparam int unsigned WPW  = (WP < 2) ? 1 : $clog2(WP),
    localparam int unsigned SLW  = (ISSUE < 2) ? 1 : $clog2(ISSUE)
) (
    input  logic [ISSUE-1:0]                       vld,
    input  logic [ISSUE-1:0][NSRC-1:0]             rneed,
    input  logic [ISSUE-1:0][NSRC-1:0][TW-1:0]     rtag,
    input  logic [ISSUE-1:0]                       wneed,
    input  logic [ISSUE-1:0][TW-1:0]               wtag,
    output logic [ISSUE-1:0]                       gnt,
    output logic [ISSUE-1:0]                       kil,
    output logic [ISSUE-1:0][NSRC-1:0][PW-1:0]     rport,
    output logic [ISSUE-1:0][WPW-1:0]              wport,
    output logic [NBANK-1:0][RP-1:0]               pt_en,
    output logic [NBANK-1:0][RP-1:0][EW-1:0]       pt_ent,
    output logic [NBANK-1:0][WP-1:0]               wt_en,
    output logic [NBANK-1:0][WP-1:0][EW-1:0]       wt_ent,
    output logic [NBANK-1:0][WP-1:0][SLW-1:0]      wt_slot
);

    localparam int unsigned CW  = $clog2(RP + 1);
    localparam int unsigned WCW = $clog2(WP + 1);

    logic [NBANK-1:0][CW-1:0]            rc;
    logic [NBANK-1:0][RP-1:0][EW-1:0]    re;
    logic [NBANK-1:0][WCW-1:0]           wc;
    logic [NBANK-1:0][WP-1:0][EW-1:0]    we;
    logic [NBANK-1:0][WP-1:0][SLW-1:0]   ws;

    // Slot-serial allocation with tentative state per slot.
    always_comb begin
        logic [NBANK-1:0][CW-1:0]          trc;
        logic [NBANK-1:0][RP-1:0][EW-1:0]  tre;
        logic [NBANK-1:0][WCW-1:0]         twc;
        logic [NBANK-1:0][WP-1:0][EW-1:0]  twe;
        logic [NBANK-1:0][WP-1:0][SLW-1:0] tws;
        logic            killed;
        logic            fit;
        logic            hit;
        logic [BW-1:0]   b;
        logic [EW-1:0]   e;
        logic [PW-1:0]   pp;
        logic [WPW-1:0]  wp;
        rc = '0; re = '0; wc = '0; we = '0; ws = '0;
        trc = '0; tre = '0; twc = '0; twe = '0; tws = '0;
        killed = 1'b0; fit = 1'b0; hit = 1'b0;
        b = '0; e = '0; pp = '0; wp = '0;
        gnt = '0; kil = '0; rport = '0; wport = '0;
        for (int i = 0; i < ISSUE; i++) begin
            trc = rc; tre = re; twc = wc; twe = we; tws = ws;
            fit = 1'b1;
            for (int s = 0; s < NSRC; s++) begin
                if (rneed[i][s]) begin
                    b   = rtag[i][s][BW-1:0];
                    e   = rtag[i][s][TW-1:BW];
                    hit = 1'b0;
                    pp  = '0;
                    for (int p = 0; p < RP; p++) begin
                        if (!hit && (CW'(p) < trc[b]) && (tre[b][p] == e)) begin
                            hit = 1'b1;
                            pp  = PW'(p);
                        end
                    end
                    if (!hit) begin
                        if (trc[b] < CW'(RP)) begin
                            pp          = PW'(trc[b]);
                            tre[b][pp]  = e;
                            trc[b]      = trc[b] + CW'(1);
                        end else begin
                            fit = 1'b0;
                        end
                    end
                    rport[i][s] = pp;
                end
            end
            if (wneed[i]) begin
                b = wtag[i][BW-1:0];
                e = wtag[i][TW-1:BW];
                if (twc[b] < WCW'(WP)) begin
                    wp          = WPW'(twc[b]);
                    twe[b][wp]  = e;
                    tws[b][wp]  = SLW'(i);
                    twc[b]      = twc[b] + WCW'(1);
                    wport[i]    = wp;
                end else begin
                    fit = 1'b0;
                end
            end
            if (vld[i] && !killed && fit) begin
                gnt[i] = 1'b1;
                rc = trc; re = tre; wc = twc; we = twe; ws = tws;
            end else begin
                rport[i] = '0;
                wport[i] = '0;
                if (vld[i]) begin
                    kil[i] = 1'b1;
                    killed = 1'b1;
                end
            end
        end
    end

    // Port tables: a port is live when its index is below the bank's final count.
    always_comb begin
        for (int bb = 0; bb < NBANK; bb++) begin
            for (int p = 0; p < RP; p++) pt_en[bb][p] = (CW'(p) < rc[bb]);
            for (int w = 0; w < WP; w++) wt_en[bb][w] = (WCW'(w) < wc[bb]);
        end
        pt_ent  = re;
        wt_ent  = we;
        wt_slot = ws;
    end

endmodule

// File: rtl/rf_bank_arb.sv
// Module rf_bank_arb
// Arbitration stage and storage of a banked physical register file. Inputs are
// one issue group per cycle; grants, kills, bank/port selects and the read data
// appear one cycle later. Granted destinations are written at the end of that
// output cycle, so the group presented next sees them.
// Assumes NREG is a multiple of NBANK and both are powers of two.
module rf_bank_arb import rfba_pkg::*; #(
    parameter int unsigned NREG  = RFBA_NREG,
    parameter int unsigned DW    = RFBA_DW,
    parameter int unsigned NBANK = RFBA_NBANK,
    parameter int unsigned RP    = RFBA_RP,
    parameter int unsigned WP    = RFBA_WP,
    parameter int unsigned ISSUE = RFBA_ISSUE,
    parameter int unsigned NSRC  = RFBA_NSRC,
    localparam int unsigned TW   = idx_w(NREG),
    localparam int unsigned BW   = idx_w(NBANK),
    localparam int unsigned PW   = idx_w(RP),
    localparam int unsigned WPW  = idx_w(WP)
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [ISSUE-1:0]                       iss_vld,
    input  logic [ISSUE-1:0][NSRC-1:0]             src_use,
    input  logic [ISSUE-1:0][NSRC-1:0]             src_byp,
    input  logic [ISSUE-1:0][NSRC-1:0][TW-1:0]     src_tag,
    input  logic [ISSUE-1:0]                       dst_use,
    input  logic [ISSUE-1:0][TW-1:0]               dst_tag,
    input  logic [ISSUE-1:0][DW-1:0]               dst_data,
    output logic [ISSUE-1:0]                       grant_vld,
    output logic [ISSUE-1:0]                       kill_mask,
    output logic [ISSUE-1:0][NSRC-1:0]             opnd_rd,
    output logic [ISSUE-1:0][NSRC-1:0][BW-1:0]     opnd_bank,
    output logic [ISSUE-1:0][NSRC-1:0][PW-1:0]     opnd_port,
    output logic [ISSUE-1:0][NSRC-1:0][DW-1:0]     opnd_data,
    output logic [ISSUE-1:0][WPW-1:0]              dst_port
);

    localparam int unsigned DEPTH = NREG / NBANK;
    localparam int unsigned EW    = TW - BW;
    localparam int unsigned SLW   = idx_w(ISSUE);
    localparam int unsigned NOPND = ISSUE * NSRC;

    logic [ISSUE-1:0][NSRC-1:0]             rneed;
    logic [ISSUE-1:0]                       gnt_d, kil_d;
    logic [ISSUE-1:0][NSRC-1:0][PW-1:0]     rport_d;
    logic [ISSUE-1:0][WPW-1:0]              wport_d;
    logic [NBANK-1:0][RP-1:0]               pt_en_d, pt_en_q;
    logic [NBANK-1:0][RP-1:0][EW-1:0]       pt_ent_d, pt_ent_q;
    logic [NBANK-1:0][WP-1:0]               wt_en_d, wt_en_q;
    logic [NBANK-1:0][WP-1:0][EW-1:0]       wt_ent_d, wt_ent_q;
    logic [NBANK-1:0][WP-1:0][SLW-1:0]      wt_slot_d;
    logic [NBANK-1:0][WP-1:0][DW-1:0]       wt_data_d, wt_data_q;
    logic [NBANK-1:0][RP-1:0][DW-1:0]       rdata;
    logic [ISSUE-1:0][NSRC-1:0][TW-1:0]     tag_q;
    logic [ISSUE-1:0][NSRC-1:0]             byp_q;
    logic [ISSUE-1:0]                       vld_q;
    logic [ISSUE-1:0]                       duse_q;
    logic [ISSUE-1:0][TW-1:0]               dtag_q;

    // Only sources present and not bypassed compete for read ports.
    assign rneed = src_use & ~src_byp;

    rfba_alloc #(
        .NBANK(NBANK), .RP(RP), .WP(WP), .ISSUE(ISSUE), .NSRC(NSRC), .TW(TW)
    ) u_alloc (
        .vld     (iss_vld),
        .rneed   (rneed),
        .rtag    (src_tag),
        .wneed   (dst_use),
        .wtag    (dst_tag),
        .gnt     (gnt_d),
        .kil     (kil_d),
        .rport   (rport_d),
        .wport   (wport_d),
        .pt_en   (pt_en_d),
        .pt_ent  (pt_ent_d),
        .wt_en   (wt_en_d),
        .wt_ent  (wt_ent_d),
        .wt_slot (wt_slot_d)
    );

    // Write data steering: each live write port takes the data of its slot.
    always_comb begin
        for (int b = 0; b < NBANK; b++)
            for (int w = 0; w < WP; w++)
                wt_data_d[b][w] = dst_data[wt_slot_d[b][w]];
    end

    // Output and port-table registers of the arbitration stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_vld <= '0;
            kill_mask <= '0;
            opnd_rd   <= '0;
            opnd_port <= '0;
            dst_port  <= '0;
            pt_en_q   <= '0;
            pt_ent_q  <= '0;
            wt_en_q   <= '0;
            wt_ent_q  <= '0;
            wt_data_q <= '0;
            tag_q     <= '0;
            byp_q     <= '0;
            vld_q     <= '0;
            duse_q    <= '0;
            dtag_q    <= '0;
        end else begin
            grant_vld <= gnt_d;
            kill_mask <= kil_d;
            for (int i = 0; i < ISSUE; i++)
                opnd_rd[i] <= rneed[i] & {NSRC{gnt_d[i]}};
            opnd_port <= rport_d;
            dst_port  <= wport_d;
            pt_en_q   <= pt_en_d;
            pt_ent_q  <= pt_ent_d;
            wt_en_q   <= wt_en_d;
            wt_ent_q  <= wt_ent_d;
            wt_data_q <= wt_data_d;
            tag_q     <= src_tag;
            byp_q     <= src_byp;
            vld_q     <= iss_vld;
            duse_q    <= dst_use;
            dtag_q    <= dst_tag;
        end
    end

    // Bank array: one multi-ported bank per generate iteration.
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        rfba_bank #(
            .DEPTH(DEPTH), .DW(DW), .RP(RP), .WP(WP)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_en   (pt_en_q[b]),
            .rd_ent  (pt_ent_q[b]),
            .rd_data (rdata[b]),
            .wr_en   (wt_en_q[b]),
            .wr_ent  (wt_ent_q[b]),
            .wr_data (wt_data_q[b])
        );
    end

    // Operand bank report and read-data return through the assigned port.
    always_comb begin
        for (int i = 0; i < ISSUE; i++)
            for (int s = 0; s < NSRC; s++) begin
                opnd_bank[i][s] = tag_q[i][s][BW-1:0];
                opnd_data[i][s] = opnd_rd[i][s]
                                ? rdata[tag_q[i][s][BW-1:0]][opnd_port[i][s]] : '0;
            end
    end

    // R3: a slot is never granted and killed together.
    a_r3_grant_kill_excl: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld & kill_mask) == '0);

    for (genvar i = 0; i < ISSUE; i++) begin : g_slot_chk
        // R10: an empty slot produces no grant and no kill.
        a_r10_idle_slot: assert property (@(posedge clk) disable iff (!rst_n)
            !vld_q[i] |-> (!grant_vld[i] && !kill_mask[i]));
        if (i + 1 < ISSUE) begin : g_chain
            // R8: a kill reaches every younger valid slot.
            a_r8_kill_chain: assert property (@(posedge clk) disable iff (!rst_n)
                (kill_mask[i] && vld_q[i+1]) |-> kill_mask[i+1]);
        end
        for (genvar s = 0; s < NSRC; s++) begin : g_src
            // R5: a bypassed source never reads the file.
            a_r5_bypass_no_read: assert property (@(posedge clk) disable iff (!rst_n)
                byp_q[i][s] |-> !opnd_rd[i][s]);
        end
        for (genvar j = i + 1; j < ISSUE; j++) begin : g_wpair
            // R9: two granted writes to one bank use different write ports.
            a_r9_wport_distinct: assert property (@(posedge clk) disable iff (!rst_n)
                (grant_vld[i] && grant_vld[j] && duse_q[i] && duse_q[j] &&
                 dtag_q[i][BW-1:0] == dtag_q[j][BW-1:0])
                |-> dst_port[i] != dst_port[j]);
        end
    end

    for (genvar k1 = 0; k1 < NOPND; k1++) begin : g_opa
        for (genvar k2 = k1 + 1; k2 < NOPND; k2++) begin : g_opb
            // R6: one read port carries one register per cycle.
            a_r6_port_one_reg: assert property (@(posedge clk) disable iff (!rst_n)
                (opnd_rd[k1/NSRC][k1%NSRC] && opnd_rd[k2/NSRC][k2%NSRC] &&
                 opnd_bank[k1/NSRC][k1%NSRC] == opnd_bank[k2/NSRC][k2%NSRC] &&
                 opnd_port[k1/NSRC][k1%NSRC] == opnd_port[k2/NSRC][k2%NSRC])
                |-> tag_q[k1/NSRC][k1%NSRC] == tag_q[k2/NSRC][k2%NSRC]);
        end
    end

endmodule

// File: tb/rf_bank_arb_test.sv
// Directed bench for rf_bank_arb: one task per scenario, each checking its results.
module rf_bank_arb_test;

    localparam int I  = 8;
    localparam int S  = 2;
    localparam int TW = 9;
    localparam int DW = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [I-1:0]               iss_vld;
    logic [I-1:0][S-1:0]        src_use, src_byp;
    logic [I-1:0][S-1:0][TW-1:0] src_tag;
    logic [I-1:0]               dst_use;
    logic [I-1:0][TW-1:0]       dst_tag;
    logic [I-1:0][DW-1:0]       dst_data;
    logic [I-1:0]               grant_vld, kill_mask;
    logic [I-1:0][S-1:0]        opnd_rd;
    logic [I-1:0][S-1:0][3:0]   opnd_bank;
    logic [I-1:0][S-1:0][1:0]   opnd_port;
    logic [I-1:0][S-1:0][DW-1:0] opnd_data;
    logic [I-1:0][0:0]          dst_port;

    rf_bank_arb uut (.*);

    int n_run = 0;
    int n_fail = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clr();
        iss_vld = '0; src_use = '0; src_byp = '0; src_tag = '0;
        dst_use = '0; dst_tag = '0; dst_data = '0;
    endtask

    task automatic rd(input int i, input int s, input logic [TW-1:0] t, input logic byp);
        iss_vld[i] = 1'b1; src_use[i][s] = 1'b1; src_tag[i][s] = t; src_byp[i][s] = byp;
    endtask

    task automatic wr(input int i, input logic [TW-1:0] t, input logic [DW-1:0] d);
        iss_vld[i] = 1'b1; dst_use[i] = 1'b1; dst_tag[i] = t; dst_data[i] = d;
    endtask

    // Present the current inputs at one edge and land on the following falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 grant after reset", 64'(grant_vld), 0);
        chk("R1 kill after reset", 64'(kill_mask), 0);
        chk("R1 opnd_rd after reset", 64'(opnd_rd), 0);
        chk("R1 ports after reset", 64'({opnd_port, dst_port}), 0);
        clr(); rd(0, 0, 9'h0A5, 1'b0);
        step();
        chk("R1 file cleared", opnd_data[0][0], 0);
        chk("R2 bank of 0x0A5", 64'(opnd_bank[0][0]), 5);
    endtask

    task automatic t_write_read();
        clr();
        wr(0, 9'h013, 64'hAAAA_0000_1111_0013);
        wr(1, 9'h023, 64'hBBBB_0000_2222_0023);
        step();
        chk("R4 two writes in bank granted", 64'(grant_vld), 64'h03);
        chk("R9 write port order", 64'({dst_port[1], dst_port[0]}), 64'b10);
        clr();
        rd(0, 0, 9'h013, 1'b0); rd(0, 1, 9'h023, 1'b0); rd(1, 0, 9'h013, 1'b0);
        step();
        chk("R11 read new value A", opnd_data[0][0], 64'hAAAA_0000_1111_0013);
        chk("R11 read new value B", opnd_data[0][1], 64'hBBBB_0000_2222_0023);
        chk("R6 shared read data", opnd_data[1][0], 64'hAAAA_0000_1111_0013);
        chk("R7 unread operand zero", opnd_data[1][1], 0);
        chk("R7 port of second register", 64'(opnd_port[0][1]), 1);
        chk("R6 shared port", 64'(opnd_port[1][0]), 0);
        chk("R2 bank of 0x023", 64'(opnd_bank[0][1]), 3);
        clr();
        step();
        chk("R3 output held one cycle", 64'(grant_vld), 0);
    endtask

    task automatic t_share_limit();
        clr();
        for (int i = 0; i < 5; i++) begin
            rd(i, 0, 9'h015, 1'b0); rd(i, 1, 9'h015, 1'b0);
        end
        rd(5, 0, 9'h025, 1'b0); rd(5, 1, 9'h035, 1'b0);
        rd(6, 0, 9'h045, 1'b0); rd(6, 1, 9'h055, 1'b0);
        iss_vld[7] = 1'b1;
        step();
        chk("R6 shared reads count once", 64'(grant_vld), 64'h3F);
        chk("R8 fifth register kills slot and younger", 64'(kill_mask), 64'hC0);
        chk("R6 same port for slot 4", 64'(opnd_port[4][1]), 0);
        chk("R7 ports for slot 5", 64'({opnd_port[5][1], opnd_port[5][0]}), 64'b1001);
        chk("R3 no grant and kill together", 64'(grant_vld & kill_mask), 0);
    endtask

    task automatic t_read_conflict();
        clr();
        rd(0, 0, 9'h002, 1'b0); rd(0, 1, 9'h012, 1'b0);
        rd(1, 0, 9'h022, 1'b0); rd(1, 1, 9'h032, 1'b0);
        rd(2, 0, 9'h042, 1'b0); rd(2, 1, 9'h007, 1'b0);
        rd(3, 0, 9'h017, 1'b0);
        iss_vld = 8'hFF;
        step();
        chk("R8 older slots granted", 64'(grant_vld), 64'h03);
        chk("R8 killed slot and younger", 64'(kill_mask), 64'hFC);
        chk("R7 fourth port assigned", 64'(opnd_port[1][1]), 3);
        chk("R8 killed slot reads nothing", 64'(opnd_rd[2]), 0);
    endtask

    task automatic t_bypass();
        clr();
        rd(0, 0, 9'h002, 1'b0); rd(0, 1, 9'h012, 1'b0);
        rd(1, 0, 9'h022, 1'b0); rd(1, 1, 9'h032, 1'b0);
        rd(2, 0, 9'h042, 1'b1); rd(2, 1, 9'h007, 1'b0);
        step();
        chk("R5 bypass lets group fit", 64'(grant_vld), 64'h07);
        chk("R5 bypassed operand not read", 64'(opnd_rd[2]), 64'b10);
        chk("R7 first port of bank 7", 64'(opnd_port[2][1]), 0);
    endtask

    task automatic t_write_conflict();
        clr();
        wr(0, 9'h009, 64'h11);
        wr(1, 9'h019, 64'h22);
        wr(2, 9'h029, 64'h33);
        wr(3, 9'h001, 64'h44);
        step();
        chk("R9 third write in bank", 64'(grant_vld), 64'h03);
        chk("R9 kill of slot and younger", 64'(kill_mask), 64'h0C);
        chk("R9 second write port", 64'(dst_port[1]), 1);
        clr();
        rd(0, 0, 9'h019, 1'b0); rd(0, 1, 9'h029, 1'b0); rd(1, 0, 9'h001, 1'b0);
        step();
        chk("R11 granted write landed", opnd_data[0][0], 64'h22);
        chk("R11 killed write absent", opnd_data[0][1], 0);
        chk("R11 younger killed write absent", opnd_data[1][0], 0);
    endtask

    task automatic t_invalid();
        clr();
        rd(0, 0, 9'h024, 1'b0); rd(0, 1, 9'h034, 1'b0);
        rd(1, 0, 9'h004, 1'b0); rd(1, 1, 9'h014, 1'b0);
        rd(2, 0, 9'h044, 1'b0); rd(2, 1, 9'h054, 1'b0);
        wr(1, 9'h0F4, 64'hDEAD);
        iss_vld[1] = 1'b0;
        step();
        chk("R10 invalid slot takes no port", 64'(grant_vld), 64'h05);
        chk("R10 invalid slot not killed", 64'(kill_mask), 0);
        chk("R10 ports after invalid slot", 64'({opnd_port[2][1], opnd_port[2][0]}), 64'b1110);
        clr();
        rd(0, 0, 9'h0F4, 1'b0);
        step();
        chk("R10 invalid slot wrote nothing", opnd_data[0][0], 0);
    endtask

    // Reference: recount distinct reads and writes per bank for each candidate slot.
    function automatic void model(output logic [I-1:0] g, output logic [I-1:0] k);
        logic [TW-1:0] gl [I*S];
        int ngl = 0;
        int wcnt [16];
        bit dead = 0;
        g = '0; k = '0;
        for (int b = 0; b < 16; b++) wcnt[b] = 0;
        for (int i = 0; i < I; i++) begin
            logic [TW-1:0] cl [I*S];
            int ncl;
            bit ok;
            if (!iss_vld[i]) continue;
            ncl = ngl;
            for (int n = 0; n < ngl; n++) cl[n] = gl[n];
            for (int s = 0; s < S; s++) begin
                bit found;
                if (!src_use[i][s] || src_byp[i][s]) continue;
                found = 0;
                for (int n = 0; n < ncl; n++) if (cl[n] == src_tag[i][s]) found = 1;
                if (!found) begin cl[ncl] = src_tag[i][s]; ncl++; end
            end
            ok = !dead;
            for (int b = 0; b < 16; b++) begin
                int c = 0;
                for (int n = 0; n < ncl; n++) if (int'(cl[n][3:0]) == b) c++;
                if (c > 4) ok = 0;
            end
            if (dst_use[i] && wcnt[dst_tag[i][3:0]] >= 2) ok = 0;
            if (ok) begin
                g[i] = 1'b1;
                ngl = ncl;
                for (int n = 0; n < ncl; n++) gl[n] = cl[n];
                if (dst_use[i]) wcnt[dst_tag[i][3:0]]++;
            end else begin
                k[i] = 1'b1;
                dead = 1;
            end
        end
    endfunction

    task automatic t_random();
        logic [I-1:0] eg, ek;
        for (int n = 0; n < 60; n++) begin
            clr();
            for (int i = 0; i < I; i++) begin
                iss_vld[i] = ($urandom % 5) != 0;
                for (int s = 0; s < S; s++) begin
                    src_use[i][s] = ($urandom % 4) != 0;
                    src_byp[i][s] = ($urandom % 6) == 0;
                    src_tag[i][s] = {5'($urandom % 3), 4'($urandom % 3)};
                end
                dst_use[i]  = ($urandom % 3) == 0;
                dst_tag[i]  = {5'($urandom % 3), 4'($urandom % 3)};
                dst_data[i] = {$urandom, $urandom};
            end
            model(eg, ek);
            step();
            chk("R8 random grant mask", 64'(grant_vld), 64'(eg));
            chk("R9 random kill mask", 64'(kill_mask), 64'(ek));
        end
        clr();
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        clr();
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_read();
        t_share_limit();
        t_read_conflict();
        t_bypass();
        t_write_conflict();
        t_invalid();
        t_random();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule